// File: doc/BRIEF.md
# Carry-Free Signed-Digit Decimal Adder

This block adds two decimal numbers held in a redundant signed-digit form. Each digit is a 4-bit two's-complement field whose legal values run from -6 to +6. In every digit position, an adder cell splits the digit sum into a transfer in {-1, 0, +1} and an interim digit in -5..+5. The result digit is that interim digit plus the transfer from the position just below. A transfer therefore moves exactly one position, and the add path has the same depth whatever the operand length. The transfer out of the top position becomes one extra most significant result digit.

From the signed-digit sum the block derives three more results with per-digit rules and no carry chain: a sign flag, a zero flag and the negated sum. A sequential reconversion unit then turns the sum into an ordinary BCD magnitude. It negates a negative sum digit by digit, then scans from the least significant digit with a borrow, at one digit per clock.

Operands enter through a valid/ready port and results leave through a second valid/ready port. One transaction is in flight at a time. The input port stays not-ready from acceptance until the result has been taken. A result with `out_valid` high is held without change for as long as `out_ready` stays low, which is how a consumer applies back-pressure.

Top module: `sd_add_unit`

## Requirements
- R1: A digit code outside -6..+6 in either operand (4-bit codes 0111, 1000 and 1001, meaning +7, -8 and -7) sets `dig_err` for that transaction. `dig_err` is low when every digit is legal.
- R2: For legal operands, every digit of `sd_sum` lies in -6..+6, and the value of `sd_sum` (NDIG+1 digits, digit i in bits [4i+3:4i], weight 10^i) equals A+B.
- R3: With s the digit sum in a position, the transfer t is +1 if s >= 6, -1 if s <= -6 and 0 otherwise, and the interim digit is s-10t. Result digit i is interim_i + t_(i-1). Position 0 receives no transfer, and the top result digit equals the transfer from position NDIG-1.
- R4: `sum_zero` is 1 exactly when every digit of `sd_sum` is zero. `sum_sign` is 1 exactly when the most significant non-zero digit of `sd_sum` is negative, which is when A+B < 0.
- R5: Digit i of `sd_neg` is the negation of digit i of `sd_sum`, so `sd_neg` has the value -(A+B).
- R6: `bcd_mag` holds |A+B| as NDIG+1 BCD digits (digit i in bits [4i+3:4i], each 0..9). The sign of the result is given by `sum_sign`.
- R7: `in_ready` is high only when the block is idle, and operands are taken on a clock edge with `in_valid` and `in_ready` both high. `out_valid` rises on the (NDIG+1)-th rising edge after that accepting edge, and `in_ready` stays low while `out_valid` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and all result outputs hold their values. An edge with `out_valid` and `out_ready` both high ends the transaction, and in the next cycle `out_valid` is low and `in_ready` is high.
- R9: While reset is asserted, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to take operands |
| in_a | input | NDIG*4 | Operand A, signed digits, least significant in the low bits |
| in_b | input | NDIG*4 | Operand B, same layout |
| out_valid | output | 1 | Result outputs valid |
| out_ready | input | 1 | Consumer takes the result |
| sd_sum | output | (NDIG+1)*4 | Signed-digit sum |
| sd_neg | output | (NDIG+1)*4 | Digit-wise negated sum |
| sum_sign | output | 1 | 1 when the sum is negative |
| sum_zero | output | 1 | 1 when the sum is zero |
| bcd_mag | output | (NDIG+1)*4 | BCD magnitude of the sum |
| dig_err | output | 1 | An operand digit was outside -6..+6 |

## Verification
The bench builds the block with NDIG = 2. At that size an operand has only 169 legal digit patterns, so every A pattern is run against every fourth B pattern. This covers every transfer combination in both positions, a carry into the extra top digit of either sign, exact cancellation to zero, and sums whose sign depends on a lower digit. Illegal codes are injected into each operand. Back-pressure on the output is applied to a spread of transactions.

// File: rtl/sd_add_pkg.sv
package sd_add_pkg;
  localparam int DIG_W   = 4;
  localparam int RADIX   = 10;
  localparam int DIG_MAX = 6;

  typedef logic signed [DIG_W-1:0] sd_t;
  typedef logic signed [1:0]       xfer_t;

  function automatic logic sd_illegal(input sd_t d);
    return (d > sd_t'(DIG_MAX)) || (d < sd_t'(-DIG_MAX));
  endfunction
endpackage

// File: rtl/sd_digit_cell.sv
module sd_digit_cell
  import sd_add_pkg::*;
(
  input  sd_t   a_i,
  input  sd_t   b_i,
  output xfer_t t_o,
  output sd_t   w_o
);
  localparam logic signed [DIG_W+1:0] HI = (DIG_W+2)'(DIG_MAX);
  localparam logic signed [DIG_W+1:0] LO = (DIG_W+2)'(-DIG_MAX);

  logic signed [DIG_W+1:0] s;
  sd_t corr;

  always_comb begin
    s = {{2{a_i[DIG_W-1]}}, a_i} + {{2{b_i[DIG_W-1]}}, b_i};
    if (s >= HI) begin
      t_o  = 2'sb01;
      corr = sd_t'(-RADIX);
    end else if (s <= LO) begin
      t_o  = 2'sb11;
      corr = sd_t'(RADIX);
    end else begin
      t_o  = 2'sb00;
      corr = '0;
    end
    // interim digit is in -5..+5, so 4-bit wrap-around arithmetic is exact
    w_o = a_i + b_i + corr;
  end
endmodule

// File: rtl/sd_adder.sv
module sd_adder
  import sd_add_pkg::*;
#(
  parameter int NDIG = 4
)(
  input  logic [NDIG*DIG_W-1:0]     a_flat,
  input  logic [NDIG*DIG_W-1:0]     b_flat,
  output logic [(NDIG+1)*DIG_W-1:0] sum_flat,
  output logic                      bad_o
);
  xfer_t           t   [NDIG];
  sd_t             w   [NDIG];
  logic [NDIG-1:0] bad;

  for (genvar i = 0; i < NDIG; i++) begin : g_pos
    sd_digit_cell u_cell (
      .a_i (sd_t'(a_flat[i*DIG_W +: DIG_W])),
      .b_i (sd_t'(b_flat[i*DIG_W +: DIG_W])),
      .t_o (t[i]),
      .w_o (w[i])
    );
    assign bad[i] = sd_illegal(sd_t'(a_flat[i*DIG_W +: DIG_W])) |
                    sd_illegal(sd_t'(b_flat[i*DIG_W +: DIG_W]));
    if (i == 0) begin : g_lsd
      assign sum_flat[i*DIG_W +: DIG_W] = w[i];
    end else begin : g_mid
      assign sum_flat[i*DIG_W +: DIG_W] = w[i] + sd_t'(t[i-1]);
    end
  end

  assign sum_flat[NDIG*DIG_W +: DIG_W] = sd_t'(t[NDIG-1]);
  assign bad_o = |bad;
endmodule

// File: rtl/sd_flags.sv
module sd_flags
  import sd_add_pkg::*;
#(
  parameter int NP = 5
)(
  input  logic [NP*DIG_W-1:0] sum_flat,
  output logic                neg_o,
  output logic                zero_o,
  output logic [NP*DIG_W-1:0] neg_flat
);
  always_comb begin
    logic found;
    found = 1'b0;
    neg_o = 1'b0;
    for (int i = NP-1; i >= 0; i--) begin
      if (!found && (sum_flat[i*DIG_W +: DIG_W] != '0)) begin
        found = 1'b1;
        neg_o = sum_flat[i*DIG_W + DIG_W - 1];
      end
    end
    zero_o = !found;
  end

  for (genvar i = 0; i < NP; i++) begin : g_neg
    assign neg_flat[i*DIG_W +: DIG_W] = -sd_t'(sum_flat[i*DIG_W +: DIG_W]);
  end
endmodule

// File: rtl/sd_reconvert.sv
module sd_reconvert
  import sd_add_pkg::*;
#(
  parameter int NP = 5
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [NP*DIG_W-1:0] din_flat,
  output logic                busy_o,
  output logic                last_o,
  output logic [NP*DIG_W-1:0] mag_flat
);
  localparam int IW = (NP > 1) ? $clog2(NP) : 1;

  sd_t             work [NP];
  logic [DIG_W-1:0] mag [NP];
  logic [IW-1:0]   idx;
  logic            borrow;
  logic            busy;
  sd_t             x;

  // digits are non-negative-valued overall; digit minus borrow stays in -7..+6
  assign x      = work[idx] - (borrow ? sd_t'(1) : sd_t'(0));
  assign busy_o = busy;
  assign last_o = busy && (idx == IW'(NP-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      borrow <= 1'b0;
    end else if (start_i) begin
      busy   <= 1'b1;
      idx    <= '0;
      borrow <= 1'b0;
    end else if (busy) begin
      idx    <= idx + 1'b1;
      borrow <= (x < 0);
      if (idx == IW'(NP-1)) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (start_i) begin
      for (int k = 0; k < NP; k++) work[k] <= sd_t'(din_flat[k*DIG_W +: DIG_W]);
    end else if (busy) begin
      mag[idx] <= (x < 0) ? DIG_W'(x + sd_t'(RADIX)) : DIG_W'(x);
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_out
    assign mag_flat[i*DIG_W +: DIG_W] = mag[i];
  end
endmodule

// File: rtl/sd_add_unit.sv
module sd_add_unit
  import sd_add_pkg::*;
#(
  parameter int NDIG = 4
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NDIG*DIG_W-1:0]     in_a,
  input  logic [NDIG*DIG_W-1:0]     in_b,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [(NDIG+1)*DIG_W-1:0] sd_sum,
  output logic [(NDIG+1)*DIG_W-1:0] sd_neg,
  output logic                      sum_sign,
  output logic                      sum_zero,
  output logic [(NDIG+1)*DIG_W-1:0] bcd_mag,
  output logic                      dig_err
);
  localparam int NP = NDIG + 1;
  localparam int SW = NP * DIG_W;

  logic          accept;
  logic [SW-1:0] add_sum, f_negd, rc_din;
  logic          add_bad, f_neg, f_zero;
  logic          rc_busy, rc_last;

  assign in_ready = !rc_busy && !out_valid;
  assign accept   = in_valid && in_ready;

  sd_adder #(.NDIG(NDIG)) u_add (
    .a_flat   (in_a),
    .b_flat   (in_b),
    .sum_flat (add_sum),
    .bad_o    (add_bad)
  );

  sd_flags #(.NP(NP)) u_flags (
    .sum_flat (add_sum),
    .neg_o    (f_neg),
    .zero_o   (f_zero),
    .neg_flat (f_negd)
  );

  // a negative sum is negated digit-wise so the scan always yields a magnitude
  assign rc_din = f_neg ? f_negd : add_sum;

  sd_reconvert #(.NP(NP)) u_rc (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (accept),
    .din_flat (rc_din),
    .busy_o   (rc_busy),
    .last_o   (rc_last),
    .mag_flat (bcd_mag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (rc_last) begin
      out_valid <= 1'b1;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      sd_sum   <= add_sum;
      sd_neg   <= f_negd;
      sum_sign <= f_neg;
      sum_zero <= f_zero;
      dig_err  <= add_bad;
    end
  end
endmodule

// File: rtl/sd_add_unit_chk.sv
module sd_add_unit_chk #(
  parameter int NDIG = 4
)(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [(NDIG+1)*4-1:0] sd_sum,
  input logic [(NDIG+1)*4-1:0] sd_neg,
  input logic                  sum_sign,
  input logic                  sum_zero,
  input logic [(NDIG+1)*4-1:0] bcd_mag,
  input logic                  dig_err
);
  localparam int NP = NDIG + 1;

  logic rng_ok, neg_ok, bcd_ok;

  always_comb begin
    rng_ok = 1'b1;
    neg_ok = 1'b1;
    bcd_ok = 1'b1;
    for (int i = 0; i < NP; i++) begin
      if ($signed(sd_sum[i*4 +: 4]) > 4'sd6 || $signed(sd_sum[i*4 +: 4]) < -4'sd6) rng_ok = 1'b0;
      if (4'(sd_sum[i*4 +: 4] + sd_neg[i*4 +: 4]) != 4'd0) neg_ok = 1'b0;
      if (bcd_mag[i*4 +: 4] > 4'd9) bcd_ok = 1'b0;
    end
  end

  p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !dig_err |-> rng_ok);

  p_zero_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && sum_zero |-> !sum_sign && (bcd_mag == '0));

  p_neg_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> neg_ok);

  p_bcd_digit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !dig_err |-> bcd_ok);

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(sd_sum) && $stable(bcd_mag) && $stable(sum_sign));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);
endmodule

bind sd_add_unit sd_add_unit_chk #(.NDIG(NDIG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .sd_sum    (sd_sum),
  .sd_neg    (sd_neg),
  .sum_sign  (sum_sign),
  .sum_zero  (sum_zero),
  .bcd_mag   (bcd_mag),
  .dig_err   (dig_err)
);

// File: tb/sd_add_unit_tb.sv
module sd_add_unit_tb;
  localparam int ND = 2;
  localparam int NP = ND + 1;
  localparam int SW = NP * 4;

  logic clk = 0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [ND*4-1:0] in_a, in_b;
  logic [SW-1:0] sd_sum, sd_neg, bcd_mag;
  logic sum_sign, sum_zero, dig_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sd_add_unit #(.NDIG(ND)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .sd_sum(sd_sum), .sd_neg(sd_neg), .sum_sign(sum_sign), .sum_zero(sum_zero),
    .bcd_mag(bcd_mag), .dig_err(dig_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dg(input logic [SW-1:0] v, input int i);
    return int'($signed(v[i*4 +: 4]));
  endfunction

  function automatic int opval(input logic [ND*4-1:0] v);
    int r = 0;
    for (int i = ND-1; i >= 0; i--) r = r*10 + int'($signed(v[i*4 +: 4]));
    return r;
  endfunction

  function automatic int sdval(input logic [SW-1:0] v);
    int r = 0;
    for (int i = NP-1; i >= 0; i--) r = r*10 + dg(v, i);
    return r;
  endfunction

  function automatic logic [ND*4-1:0] pk(input int k);
    return {4'(k/13 - 6), 4'(k%13 - 6)};
  endfunction

  task automatic run_tx(input logic [ND*4-1:0] a, input logic [ND*4-1:0] b,
                        input bit hold, input bit exp_err);
    int lat, w, ev, av, tprev, s, t, mag, bad_i;
    int exp_d [NP];
    logic [SW-1:0] exp_bcd, snap_sum, snap_bcd;
    @(negedge clk);
    lat = 0;
    while (!in_ready && lat < 40) begin @(negedge clk); lat++; end
    chk(in_ready == 1'b1, "R7", "in_ready when idle", in_ready, 1);
    in_a = a; in_b = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == ND+1, "R7", "result latency", lat, ND+1);
    chk(dig_err == exp_err, "R1", "illegal digit flag", dig_err, exp_err);
    if (!exp_err) begin
      ev = opval(a) + opval(b);
      // R3 transfer rule in integer form
      tprev = 0;
      for (int i = 0; i < ND; i++) begin
        s = int'($signed(a[i*4 +: 4])) + int'($signed(b[i*4 +: 4]));
        t = (s >= 6) ? 1 : ((s <= -6) ? -1 : 0);
        w = s - 10*t;
        exp_d[i] = w + tprev;
        tprev = t;
      end
      exp_d[ND] = tprev;
      bad_i = -1;
      for (int i = 0; i < NP; i++) if (dg(sd_sum, i) != exp_d[i] && bad_i < 0) bad_i = i;
      chk(bad_i < 0, "R3", "per-digit sum", (bad_i < 0) ? 0 : dg(sd_sum, bad_i),
          (bad_i < 0) ? 0 : exp_d[bad_i]);
      chk(sdval(sd_sum) == ev, "R2", "sum value", sdval(sd_sum), ev);
      chk(sum_zero == (ev == 0), "R4", "zero flag", sum_zero, ev == 0);
      chk(sum_sign == (ev < 0), "R4", "sign flag", sum_sign, ev < 0);
      bad_i = -1;
      for (int i = 0; i < NP; i++) if (dg(sd_neg, i) != -dg(sd_sum, i) && bad_i < 0) bad_i = i;
      chk(bad_i < 0 && sdval(sd_neg) == -ev, "R5", "negated sum", sdval(sd_neg), -ev);
      av = (ev < 0) ? -ev : ev;
      mag = av;
      exp_bcd = '0;
      for (int i = 0; i < NP; i++) begin
        exp_bcd[i*4 +: 4] = 4'(mag % 10);
        mag = mag / 10;
      end
      chk(bcd_mag == exp_bcd, "R6", "bcd magnitude", bcd_mag, exp_bcd);
    end
    if (hold) begin
      snap_sum = sd_sum; snap_bcd = bcd_mag;
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk(out_valid && sd_sum == snap_sum && bcd_mag == snap_bcd, "R8",
          "hold under back-pressure", out_valid, 1);
      chk(in_ready == 1'b0, "R7", "no accept while result pending", in_ready, 0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R8", "release after handshake", out_valid, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R9", "in_ready in reset", in_ready, 1);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;

    // directed corners: top-digit transfer both ways, exact cancellation
    run_tx({4'sd6, 4'sd6}, {4'sd6, 4'sd6}, 1'b1, 1'b0);
    run_tx({-4'sd6, -4'sd6}, {-4'sd6, -4'sd6}, 1'b0, 1'b0);
    run_tx({4'sd6, -4'sd6}, {-4'sd6, 4'sd6}, 1'b0, 1'b0);
    run_tx({4'sd1, -4'sd6}, {4'sd0, -4'sd1}, 1'b1, 1'b0);

    // R1 illegal codes: +7, -7, -8 in either operand and either position
    run_tx({4'sd0, 4'b0111}, {4'sd0, 4'sd0}, 1'b0, 1'b1);
    run_tx({4'sd0, 4'sd0}, {4'b1001, 4'sd0}, 1'b0, 1'b1);
    run_tx({4'b1000, 4'sd2}, {4'sd1, 4'sd0}, 1'b0, 1'b1);
    run_tx({4'sd3, 4'sd1}, {4'sd0, 4'b1000}, 1'b0, 1'b1);

    // near-exhaustive sweep over legal operand pairs
    for (int ka = 0; ka < 169; ka++) begin
      for (int kb = 0; kb < 169; kb += 4) begin
        run_tx(pk(ka), pk(kb), ((ka*169 + kb) % 97) == 0, 1'b0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule